// File: doc/BRIEF.md
# Dual-Role USB Host/Peripheral Role Selector

This block decides whether a dual-role USB controller runs as host or as peripheral. It watches the cable identification level, a configuration bit that pins the controller to host operation, a bit that allows role swapping, a one-cycle pulse from the swap protocol engine announcing a finished role change, the bus-supply comparator and a bit that bypasses supply sensing. From these it produces a host flag, an enable for the data-line pull-down resistors, a qualified bus-supply flag and the cable-end indication.

The identification level is a slow external signal, so it passes through a synchronizer and a debounce filter before it can steer the role. The supply comparator is synchronized as well. The swap pulse and the configuration bits come from the same clock domain and act on the next edge. The role itself is held in a register, so every output is free of glitches. All pins are plain level or pulse controls; no data flows through the block, so it has no valid/ready handshake and never stalls anything.

Top module: `otg_role_select`

## Requirements
- R1: While reset is asserted and directly after it, host flag = 0, pull-down enable = 0, supply-valid flag = 0 and cable-end indication = 1 (peripheral-end).
- R2: With the force-host bit set before a clock edge, the host flag is 1 after that edge, whatever the identification level is; clearing it hands the role back to the identification logic on the next edge.
- R3: The identification level 0 marks the host-end plug and 1 the peripheral-end plug. A change that stays put moves the cable-end indication after DEBOUNCE+SYNC_STAGES edges and the host flag after DEBOUNCE+SYNC_STAGES+1 edges.
- R4: A change of the identification level that lasts fewer than DEBOUNCE cycles changes no output.
- R5: With a host-end plug the controller is host, whether the swap-enable bit is set or clear.
- R6: At the peripheral end, a swap pulse while the swap-enable bit and the supply-valid flag are both 1 makes the host flag 1 after the next edge.
- R7: A swap pulse is ignored when the swap-enable bit is 0 or the supply-valid flag is 0.
- R8: A peripheral-end controller that took the host role through a swap returns to peripheral one edge after the supply-valid flag falls, that is SYNC_STAGES+2 edges after the comparator falls.
- R9: A swapped host that sees the identification level go to the host end stays host; when the level later returns to the peripheral end, it becomes peripheral and does not resume the swapped host role.
- R10: The pull-down enable equals the host flag in every cycle.
- R11: With the sensing bypass bit set, the supply-valid flag is 1 after the next edge regardless of the comparator; with it clear the flag follows the comparator SYNC_STAGES+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_level_i | input | 1 | Cable identification level, 0 = host-end plug, asynchronous |
| force_host_i | input | 1 | Pins the controller to host operation, identification ignored |
| hnp_capable_i | input | 1 | Allows a peripheral-end controller to take the host role |
| hnp_swap_done_i | input | 1 | One-cycle pulse: role swap protocol finished |
| vbus_cmp_i | input | 1 | Bus-supply comparator output, asynchronous |
| vbus_sense_off_i | input | 1 | Bypass supply sensing; supply then reads valid |
| host_mode_o | output | 1 | Controller acts as host |
| dline_pd_en_o | output | 1 | Enable for pull-downs on both data lines |
| vbus_valid_o | output | 1 | Qualified bus-supply valid flag |
| b_device_o | output | 1 | Debounced cable end, 1 = peripheral end |

## Verification
Directed sequences step each input across an edge and sample on both sides of the expected edge, which separates a correct latency from one that is one cycle short or long in the synchronizer, the debounce counter or the role register. A glitch one cycle shorter than the debounce window against a change exactly as long as the window separates filtering from pass-through. Swap pulses are tried with the enable bit clear, with the supply invalid and with both in place, which tells a gated swap from an ungated one. A seeded random walk toggles one input at a time and fires swap pulses, comparing all outputs with a bench model of the settled role; it finds wrong priorities between forced host, host-end plug and swapped host, and a swapped role that survives when it should end.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
  typedef enum logic [1:0] {
    ROLE_PERIPH = 2'd0,
    ROLE_A_HOST = 2'd1,
    ROLE_B_HOST = 2'd2,
    ROLE_FORCED = 2'd3
  } role_e;
endpackage

// File: rtl/rsel_sync.sv
module rsel_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsel_debounce.sv
module rsel_debounce #(
  parameter int   HOLD      = 8,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;

  // Count consecutive cycles where the input disagrees with the held level;
  // any agreement restarts the window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= RESET_VAL;
    end else if (d_i != level_q) begin
      if (cnt_q == LAST) begin
        level_q <= d_i;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign q_o = level_q;
endmodule

// File: rtl/rsel_role_fsm.sv
module rsel_role_fsm
  import rsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic force_host_i,
  input  logic b_side_i,
  input  logic hnp_capable_i,
  input  logic swap_done_i,
  input  logic vbus_ok_i,
  output logic host_o
);
  role_e role_q, role_d;

  always_comb begin
    if (force_host_i)
      role_d = ROLE_FORCED;
    else if (!b_side_i)
      role_d = ROLE_A_HOST;
    else if (role_q == ROLE_B_HOST && vbus_ok_i)
      role_d = ROLE_B_HOST;
    else if (role_q == ROLE_PERIPH && swap_done_i && hnp_capable_i && vbus_ok_i)
      role_d = ROLE_B_HOST;
    else
      role_d = ROLE_PERIPH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) role_q <= ROLE_PERIPH;
    else        role_q <= role_d;
  end

  assign host_o = (role_q != ROLE_PERIPH);
endmodule

// File: rtl/otg_role_select.sv
module otg_role_select #(
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic id_level_i,
  input  logic force_host_i,
  input  logic hnp_capable_i,
  input  logic hnp_swap_done_i,
  input  logic vbus_cmp_i,
  input  logic vbus_sense_off_i,
  output logic host_mode_o,
  output logic dline_pd_en_o,
  output logic vbus_valid_o,
  output logic b_device_o
);
  logic id_sync;
  logic id_stable;
  logic vbus_sync;
  logic vbus_ok_q;
  logic host;

  rsel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_id_sync (
    .clk(clk), .rst_n(rst_n), .d_i(id_level_i), .q_o(id_sync)
  );

  rsel_debounce #(.HOLD(DEBOUNCE), .RESET_VAL(1'b1)) u_id_deb (
    .clk(clk), .rst_n(rst_n), .d_i(id_sync), .q_o(id_stable)
  );

  rsel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_vbus_sync (
    .clk(clk), .rst_n(rst_n), .d_i(vbus_cmp_i), .q_o(vbus_sync)
  );

  // Bypass wins over the comparator; one register keeps the flag glitch-free.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vbus_ok_q <= 1'b0;
    else        vbus_ok_q <= vbus_sense_off_i | vbus_sync;
  end

  rsel_role_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .force_host_i(force_host_i),
    .b_side_i(id_stable),
    .hnp_capable_i(hnp_capable_i),
    .swap_done_i(hnp_swap_done_i),
    .vbus_ok_i(vbus_ok_q),
    .host_o(host)
  );

  assign host_mode_o   = host;
  assign dline_pd_en_o = host;
  assign vbus_valid_o  = vbus_ok_q;
  assign b_device_o    = id_stable;
endmodule

// File: rtl/otg_role_select_chk.sv
module otg_role_select_chk (
  input logic clk,
  input logic rst_n,
  input logic force_host_i,
  input logic hnp_capable_i,
  input logic vbus_sense_off_i,
  input logic host_mode_o,
  input logic vbus_valid_o,
  input logic b_device_o
);
  a_r2_force_host: assert property (@(posedge clk) disable iff (!rst_n)
    force_host_i |=> host_mode_o);

  a_r5_a_side_host: assert property (@(posedge clk) disable iff (!rst_n)
    !b_device_o |=> host_mode_o);

  a_r7_no_swap_without_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode_o && !force_host_i && !hnp_capable_i && b_device_o) |=> !host_mode_o);

  a_r8_vbus_loss_ends_b_host: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode_o && !force_host_i && b_device_o && !vbus_valid_o) |=> !host_mode_o);

  a_r11_sense_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    vbus_sense_off_i |=> vbus_valid_o);
endmodule

bind otg_role_select otg_role_select_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .force_host_i(force_host_i), .hnp_capable_i(hnp_capable_i),
  .vbus_sense_off_i(vbus_sense_off_i),
  .host_mode_o(host_mode_o), .vbus_valid_o(vbus_valid_o),
  .b_device_o(b_device_o)
);

// File: tb/otg_role_select_tb.sv
module otg_role_select_tb;
  localparam int SYNC = 2;
  localparam int DEB  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_l = 1'b1, frc = 1'b0, cap = 1'b0, swp = 1'b0, cmp = 1'b0, soff = 1'b0;
  logic host, pd, vv, bdev;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otg_role_select #(.SYNC_STAGES(SYNC), .DEBOUNCE(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .id_level_i(id_l), .force_host_i(frc),
    .hnp_capable_i(cap), .hnp_swap_done_i(swp), .vbus_cmp_i(cmp),
    .vbus_sense_off_i(soff), .host_mode_o(host), .dline_pd_en_o(pd),
    .vbus_valid_o(vv), .b_device_o(bdev)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // R10: pull-down enable checked against the expected host flag every time.
  task automatic chk_all(string req, logic eh, logic ev, logic eb);
    check(req, host, eh);
    check({req, "/R10"}, pd, eh);
    check(req, vv, ev);
    check(req, bdev, eb);
  endtask

  function automatic logic exp_host(logic f, logic idv, logic bh);
    return f | ~idv | bh;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic bh;
    void'($urandom(32'd1234));
    step(3);
    chk_all("R1 in reset", 0, 0, 1);
    rst_n = 1'b1;
    step(1);
    chk_all("R1 after reset", 0, 0, 1);

    // R11: bypass takes one edge, comparator takes SYNC+1 edges
    soff = 1'b1;
    step(1);
    check("R11 bypass", vv, 1);
    soff = 1'b0;
    step(1);
    check("R11 bypass off, cmp low", vv, 0);
    cmp = 1'b1;
    step(SYNC);
    check("R11 cmp before latency", vv, 0);
    step(1);
    check("R11 cmp after latency", vv, 1);

    // R2: force-host in one edge, id ignored
    frc = 1'b1;
    step(1);
    check("R2 force host", host, 1);
    id_l = 1'b0;
    step(DEB + 4);
    id_l = 1'b1;
    step(DEB + 4);
    check("R2 id ignored under force", host, 1);
    frc = 1'b0;
    step(1);
    check("R2 force cleared", host, 0);

    // R3: exact debounce latency
    id_l = 1'b0;
    step(DEB + SYNC - 1);
    check("R3 b_device before latency", bdev, 1);
    step(1);
    check("R3 b_device after latency", bdev, 0);
    check("R3 host one edge later, before", host, 0);
    step(1);
    check("R3 host after latency", host, 1);
    // R5: host-end plug stays host with swap enable on and off
    cap = 1'b1;
    step(2);
    check("R5 A-side host, cap=1", host, 1);
    cap = 1'b0;
    step(2);
    check("R5 A-side host, cap=0", host, 1);
    id_l = 1'b1;
    step(DEB + SYNC + 1);
    chk_all("R3 back to peripheral end", 0, 1, 1);

    // R4: glitch one cycle short of the window
    id_l = 1'b0;
    step(DEB - 1);
    id_l = 1'b1;
    for (int i = 0; i < DEB + 4; i++) begin
      step(1);
      check("R4 glitch filtered", bdev, 1);
      check("R4 glitch no host", host, 0);
    end

    // R7: swap ignored without enable, then without supply
    swp = 1'b1; step(1); swp = 1'b0;
    check("R7 swap without cap", host, 0);
    cap = 1'b1;
    cmp = 1'b0;
    step(SYNC + 2);
    check("R7 supply invalid", vv, 0);
    swp = 1'b1; step(1); swp = 1'b0;
    check("R7 swap without vbus", host, 0);
    cmp = 1'b1;
    step(SYNC + 2);

    // R6: swap accepted
    swp = 1'b1; step(1); swp = 1'b0;
    check("R6 swap to host", host, 1);
    step(3);
    check("R6 swapped host holds", host, 1);

    // R8: supply loss ends swapped host after SYNC+2 edges
    cmp = 1'b0;
    step(SYNC + 1);
    check("R8 host before latency", host, 1);
    step(1);
    check("R8 host dropped", host, 0);

    // R9: id change during swapped host
    cmp = 1'b1;
    step(SYNC + 2);
    swp = 1'b1; step(1); swp = 1'b0;
    check("R9 swap again", host, 1);
    id_l = 1'b0;
    step(DEB + SYNC + 2);
    check("R9 A-side keeps host", host, 1);
    id_l = 1'b1;
    step(DEB + SYNC + 2);
    check("R9 back to peripheral", host, 0);

    // Random walk against a settled-state model (R2 R5 R6 R7 R8 R9 R11)
    bh = 1'b0;
    for (int it = 0; it < 300; it++) begin
      int k;
      k = int'($urandom % 6);
      if (k == 5) begin
        if (!frc && id_l && cap && (soff | cmp)) bh = 1'b1;
        swp = 1'b1; step(1); swp = 1'b0;
        step(1);
      end else begin
        logic v;
        v = logic'($urandom % 2);
        case (k)
          0: frc = v;
          1: id_l = v;
          2: cap = v;
          3: cmp = v;
          default: soff = v;
        endcase
        step(DEB + 8);
        if (frc || !id_l || !(soff | cmp)) bh = 1'b0;
      end
      chk_all("R6/R8 random settled", exp_host(frc, id_l, bh), soff | cmp, id_l);
    end

    done = 1'b1;
    summary();
  end
endmodule